// File: doc/BRIEF.md
# Burst Preamble Detector and Phase Estimator

This block sits in the acquisition branch of a burst-mode receiver. It receives one recovered bit per valid cycle. With each bit comes the phase of the edge that ended the previous bit. The block hunts for an alternating 0/1 run. It counts the transitions in that run against a programmable threshold. Meanwhile it averages the phases of the run's edges over a selectable window. When the threshold is reached, it raises a one-cycle detection flag and publishes the averaged phase. If burst steering is enabled, it also raises a one-cycle steer strobe, which a tracking oscillator can use to jump straight to the new burst's phase.

Phase uses 10-bit codes, so 1024 steps make one full turn. Each edge phase is first taken relative to the first edge of the current segment, as a signed offset in the range -512..511. The offsets are then summed and scaled by a right shift. Because of this, a preamble whose edges straddle the wrap point is averaged without bias. A preamble longer than the threshold simply starts a new segment after each detection, so it yields back-to-back detections.

The control is a four-state machine:
- NOREF: no previous bit is held yet.
- SEEK: a previous bit is held, but the segment has no edges yet.
- ACCUM: the segment's edges are being summed into the window.
- COUNT: the window is full and the remaining edges are counted up to the threshold.

Transitions:
- The first valid bit moves NOREF to SEEK.
- An edge in SEEK moves to ACCUM, or to COUNT if the window is a single edge.
- The edge that fills the window moves ACCUM to COUNT.
- The edge that reaches the threshold (a detection), or any repeated bit (a break), returns ACCUM, COUNT or SEEK to SEEK.

Top module: `burst_preamble_detector`

## Requirements
- R1: An edge is a valid bit that differs from the previous valid bit. When the edge count of the current segment reaches the threshold, `found_o` is high for exactly the one cycle after that bit's clock edge.
- R2: `run_len_i` is a 6-bit unsigned threshold, counted in edges. The value 0 means 64.
- R3: A valid bit equal to the previous valid bit clears the edge count. The next edge then starts a fresh segment, whose first edge becomes the new phase reference.
- R4: After a detection the edge count restarts from zero. A run of k·T edges at threshold T therefore gives k detections.
- R5: `steer_o` pulses together with `found_o` only if `steer_en_i` was high at the detecting bit. `found_o` pulses regardless of `steer_en_i`.
- R6: `steer_phase_o` = (P0 + floor(S / W)) mod 1024. Here P0 is the segment's first edge phase, and S is the sum of the first W edges' offsets from P0. Each offset is taken modulo 1024 and read as signed (-512..511).
- R7: The window size is W = min(16·2^`avg_sel_i`, largest power of two not above the threshold). For `avg_sel_i`, code 0 gives 16, 1 gives 32, 2 gives 64 and 3 gives 128.
- R8: `steer_phase_o` is loaded at every detection, whatever the value of `steer_en_i`. It holds its value in every other cycle.
- R9: Cycles with `bit_vld_i` low are ignored. They neither break nor extend a run.
- R10: After reset all outputs are zero. The first valid bit after reset only becomes the reference bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Recovered bit valid |
| bit_i | input | 1 | Recovered bit |
| edge_ph_i | input | 10 | Phase of the edge ending the previous bit; 1024 steps per turn |
| run_len_i | input | 6 | Detection threshold in edges; 0 means 64 |
| avg_sel_i | input | 2 | Averaging window code (16/32/64/128 edges) |
| steer_en_i | input | 1 | Allows the steer strobe |
| found_o | output | 1 | One-cycle preamble detection pulse |
| steer_o | output | 1 | One-cycle steer command |
| steer_phase_o | output | 10 | Averaged phase of the latest detection |

## Verification
The bound checker watches four relations on every cycle:
- A steer strobe never appears without a detection pulse.
- A steer strobe appears exactly when steering was enabled at the detecting bit.
- A detection always follows a valid bit.
- The phase output never moves outside a detection.

Only the bench scenarios can show the rest: where detections fall in a bit sequence, the 0-means-64 threshold, segment restart after a break or a detection, window clamping and selection, gap tolerance, an unbiased mean across the wrap point, and the absence of false detections on random data.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

    // Segment states of the run tracker
    typedef enum logic [1:0] {
        ST_NOREF = 2'd0,   // no previous bit held yet
        ST_SEEK  = 2'd1,   // previous bit held, segment has no edges
        ST_ACCUM = 2'd2,   // summing edge offsets into the window
        ST_COUNT = 2'd3    // window full, counting up to the threshold
    } run_state_t;

endpackage

// File: rtl/bpd_window_sel.sv
module bpd_window_sel #(
    parameter int THR_W   = 6,
    parameter int SEL_W   = 2,
    parameter int MIN_LOG = 4,
    parameter int CNT_W   = THR_W + 1,
    parameter int LOG_W   = 3
) (
    input  logic [THR_W-1:0] thr_code_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] thr_eff_o,
    output logic [LOG_W-1:0] win_log_o
);

    logic [LOG_W-1:0] thr_log;
    logic [LOG_W-1:0] sel_log;

    // Zero threshold code stands for the full 2^THR_W count
    always_comb begin
        if (thr_code_i == '0)
            thr_eff_o = CNT_W'(1) << THR_W;
        else
            thr_eff_o = {1'b0, thr_code_i};
    end

    // Floor log2 of the effective threshold (highest set bit)
    always_comb begin
        thr_log = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (thr_eff_o[i])
                thr_log = LOG_W'(i);
        end
    end

    assign sel_log = LOG_W'(MIN_LOG) + LOG_W'(sel_i);

    // Window may not exceed the edges available before detection
    assign win_log_o = (sel_log < thr_log) ? sel_log : thr_log;

endmodule

// File: rtl/bpd_run_fsm.sv
module bpd_run_fsm
    import bpd_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int LOG_W  = 3,
    parameter int FILL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld_i,
    input  logic             bit_i,
    input  logic [CNT_W-1:0] thr_eff_i,
    input  logic [LOG_W-1:0] win_log_i,
    output logic             first_o,
    output logic             acc_add_o,
    output logic             fire_o
);

    run_state_t        state_q, state_d;
    logic              prev_q;
    logic [CNT_W-1:0]  edge_cnt_q;
    logic [FILL_W-1:0] fill_cnt_q;
    logic [FILL_W-1:0] win_n;
    logic              edge_seen;
    logic              pair_same;
    logic              win_full_nxt;

    assign win_n        = FILL_W'(1) << win_log_i;
    assign edge_seen    = bit_vld_i && (state_q != ST_NOREF) && (bit_i != prev_q);
    assign pair_same    = bit_vld_i && (state_q != ST_NOREF) && (bit_i == prev_q);
    assign win_full_nxt = (fill_cnt_q + FILL_W'(1)) == win_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_NOREF;
        else
            state_q <= state_d;
    end

    // Segment counters and reference bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q     <= 1'b0;
            edge_cnt_q <= '0;
            fill_cnt_q <= '0;
        end else if (bit_vld_i) begin
            prev_q <= bit_i;
            if (fire_o || pair_same) begin
                edge_cnt_q <= '0;
                fill_cnt_q <= '0;
            end else if (edge_seen) begin
                edge_cnt_q <= edge_cnt_q + CNT_W'(1);
                if (acc_add_o)
                    fill_cnt_q <= fill_cnt_q + FILL_W'(1);
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NOREF: begin
                if (bit_vld_i)
                    state_d = ST_SEEK;
            end
            ST_SEEK: begin
                if (edge_seen && !fire_o)
                    state_d = (win_n == FILL_W'(1)) ? ST_COUNT : ST_ACCUM;
            end
            ST_ACCUM: begin
                if (pair_same || fire_o)
                    state_d = ST_SEEK;
                else if (edge_seen && win_full_nxt)
                    state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (pair_same || fire_o)
                    state_d = ST_SEEK;
            end
            default: state_d = ST_NOREF;
        endcase
    end

    // Control outputs
    always_comb begin
        fire_o    = edge_seen && ((edge_cnt_q + CNT_W'(1)) == thr_eff_i);
        first_o   = edge_seen && (state_q == ST_SEEK);
        acc_add_o = edge_seen && ((state_q == ST_SEEK) || (state_q == ST_ACCUM));
    end

endmodule

// File: rtl/bpd_phase_acc.sv
module bpd_phase_acc #(
    parameter int PH_W  = 10,
    parameter int LOG_W = 3,
    parameter int ACC_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  edge_ph_i,
    input  logic             first_i,
    input  logic             acc_add_i,
    input  logic [LOG_W-1:0] win_log_i,
    output logic [PH_W-1:0]  est_o
);

    logic [PH_W-1:0]         ref_q;
    logic signed [ACC_W-1:0] sum_q;
    logic [PH_W-1:0]         rel_raw;
    logic signed [ACC_W-1:0] rel_x;
    logic signed [ACC_W-1:0] sum_cand;
    logic signed [ACC_W-1:0] mean;
    logic [PH_W-1:0]         ref_cand;

    // Modular difference, read as signed: wrap-safe offset
    assign rel_raw = edge_ph_i - ref_q;
    assign rel_x   = {{(ACC_W-PH_W){rel_raw[PH_W-1]}}, rel_raw};

    always_comb begin
        if (first_i)
            sum_cand = '0;
        else if (acc_add_i)
            sum_cand = sum_q + rel_x;
        else
            sum_cand = sum_q;
        ref_cand = first_i ? edge_ph_i : ref_q;
        mean     = sum_cand >>> win_log_i;
        est_o    = ref_cand + mean[PH_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= '0;
            sum_q <= '0;
        end else if (first_i) begin
            ref_q <= edge_ph_i;
            sum_q <= '0;
        end else if (acc_add_i) begin
            sum_q <= sum_q + rel_x;
        end
    end

endmodule

// File: rtl/burst_preamble_detector.sv
module burst_preamble_detector #(
    parameter int PH_W    = 10,
    parameter int THR_W   = 6,
    parameter int SEL_W   = 2,
    parameter int MIN_LOG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld_i,
    input  logic             bit_i,
    input  logic [PH_W-1:0]  edge_ph_i,
    input  logic [THR_W-1:0] run_len_i,
    input  logic [SEL_W-1:0] avg_sel_i,
    input  logic             steer_en_i,
    output logic             found_o,
    output logic             steer_o,
    output logic [PH_W-1:0]  steer_phase_o
);

    localparam int CNT_W   = THR_W + 1;
    localparam int MAX_LOG = MIN_LOG + (1 << SEL_W) - 1;
    localparam int LOG_W   = $clog2(MAX_LOG + 1);
    localparam int FILL_W  = MAX_LOG + 1;
    localparam int ACC_W   = PH_W + MAX_LOG + 1;

    logic [CNT_W-1:0] thr_eff;
    logic [LOG_W-1:0] win_log;
    logic             seg_first;
    logic             seg_add;
    logic             seg_fire;
    logic [PH_W-1:0]  est;

    bpd_window_sel #(
        .THR_W  (THR_W),
        .SEL_W  (SEL_W),
        .MIN_LOG(MIN_LOG),
        .CNT_W  (CNT_W),
        .LOG_W  (LOG_W)
    ) u_win (
        .thr_code_i(run_len_i),
        .sel_i     (avg_sel_i),
        .thr_eff_o (thr_eff),
        .win_log_o (win_log)
    );

    bpd_run_fsm #(
        .CNT_W (CNT_W),
        .LOG_W (LOG_W),
        .FILL_W(FILL_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld_i(bit_vld_i),
        .bit_i    (bit_i),
        .thr_eff_i(thr_eff),
        .win_log_i(win_log),
        .first_o  (seg_first),
        .acc_add_o(seg_add),
        .fire_o   (seg_fire)
    );

    bpd_phase_acc #(
        .PH_W (PH_W),
        .LOG_W(LOG_W),
        .ACC_W(ACC_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_ph_i(edge_ph_i),
        .first_i  (seg_first),
        .acc_add_i(seg_add),
        .win_log_i(win_log),
        .est_o    (est)
    );

    // Registered result stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            found_o       <= 1'b0;
            steer_o       <= 1'b0;
            steer_phase_o <= '0;
        end else begin
            found_o <= seg_fire;
            steer_o <= seg_fire && steer_en_i;
            if (seg_fire)
                steer_phase_o <= est;
        end
    end

endmodule

// File: rtl/bpd_checker.sv
module bpd_checker #(
    parameter int PH_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bit_vld_i,
    input logic            steer_en_i,
    input logic            found_o,
    input logic            steer_o,
    input logic [PH_W-1:0] steer_phase_o
);

    p_steer_has_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        steer_o |-> found_o);

    p_steer_only_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        steer_o |-> $past(steer_en_i));

    p_enabled_flag_steers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o && $past(steer_en_i)) |-> steer_o);

    p_flag_after_valid_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> $past(bit_vld_i));

    p_phase_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !found_o |-> $stable(steer_phase_o));

endmodule

bind burst_preamble_detector bpd_checker #(.PH_W(PH_W)) u_bpd_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_vld_i    (bit_vld_i),
    .steer_en_i   (steer_en_i),
    .found_o      (found_o),
    .steer_o      (steer_o),
    .steer_phase_o(steer_phase_o)
);

// File: tb/burst_preamble_detector_test.sv
module burst_preamble_detector_test;

    localparam int PH_W = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bit_vld_i = 1'b0;
    logic            bit_i = 1'b0;
    logic [PH_W-1:0] edge_ph_i = '0;
    logic [5:0]      run_len_i = 6'd8;
    logic [1:0]      avg_sel_i = 2'd0;
    logic            steer_en_i = 1'b1;
    logic            found_o;
    logic            steer_o;
    logic [PH_W-1:0] steer_phase_o;

    burst_preamble_detector uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_vld_i    (bit_vld_i),
        .bit_i        (bit_i),
        .edge_ph_i    (edge_ph_i),
        .run_len_i    (run_len_i),
        .avg_sel_i    (avg_sel_i),
        .steer_en_i   (steer_en_i),
        .found_o      (found_o),
        .steer_o      (steer_o),
        .steer_phase_o(steer_phase_o)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int found_n = 0;
    int last_ph = 0;
    logic [PH_W:0] exp_q[$];

    // Reference model state (built from the requirements)
    bit m_has_prev = 0;
    bit m_prev = 0;
    int m_cnt = 0;
    int m_fill = 0;
    int m_ref = 0;
    int m_sum = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_step(input bit b, input int ph);
        int thr, wlim, w, lg, r, est;
        if (!m_has_prev) begin
            m_has_prev = 1;
            m_prev = b;
            return;
        end
        if (b == m_prev) begin
            m_cnt = 0;
            m_fill = 0;
            return;
        end
        thr = (run_len_i == 0) ? 64 : int'(run_len_i);
        wlim = 1;
        while (wlim * 2 <= thr) wlim = wlim * 2;
        w = 16 << avg_sel_i;
        if (wlim < w) w = wlim;
        lg = 0;
        while ((1 << lg) < w) lg++;
        if (m_cnt == 0) begin
            m_ref = ph;
            m_sum = 0;
            m_fill = 1;
        end else if (m_fill < w) begin
            r = (ph - m_ref) & 1023;
            if (r >= 512) r = r - 1024;
            m_sum = m_sum + r;
            m_fill++;
        end
        m_cnt++;
        m_prev = b;
        if (m_cnt == thr) begin
            est = (m_ref + (m_sum >>> lg)) & 1023;
            exp_q.push_back({steer_en_i, PH_W'(est)});
            m_cnt = 0;
            m_fill = 0;
        end
    endtask

    task automatic drive_bit(input bit b, input int ph);
        @(negedge clk);
        bit_vld_i = 1'b1;
        bit_i     = b;
        edge_ph_i = PH_W'(ph & 1023);
        model_step(b, ph & 1023);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_vld_i = 1'b0;
        end
    endtask

    task automatic send_alt(input int n, input int ph);
        for (int i = 0; i < n; i++) drive_bit(!m_prev, ph);
    endtask

    task automatic break_run();
        drive_bit(m_prev, 0);
    endtask

    // Scoreboard monitor: samples 2 ns after each rising edge
    initial begin
        logic [PH_W:0] item;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #2;
            if (found_o) begin
                found_n++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected detection", 1, 0);
                end else begin
                    item = exp_q.pop_front();
                    chk(steer_o == item[PH_W], "R5 steer strobe", int'(steer_o), int'(item[PH_W]));
                    chk(steer_phase_o == item[PH_W-1:0], "R6 phase estimate",
                        int'(steer_phase_o), int'(item[PH_W-1:0]));
                    last_ph = int'(item[PH_W-1:0]);
                end
            end else begin
                if (exp_q.size() != 0) begin
                    item = exp_q.pop_front();
                    chk(1'b0, "R1 missing detection", 0, 1);
                end
                if (steer_o) chk(1'b0, "R5 steer without flag", 1, 0);
                if (int'(steer_phase_o) != last_ph)
                    chk(1'b0, "R8 phase held", int'(steer_phase_o), last_ph);
            end
        end
    end

    // Watchdog
    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int f0;
        int d;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(found_o == 1'b0, "R10 reset flag", int'(found_o), 0);
        chk(steer_o == 1'b0, "R10 reset steer", int'(steer_o), 0);
        chk(steer_phase_o == '0, "R10 reset phase", int'(steer_phase_o), 0);
        rst_n = 1'b1;

        // R10/R1: first bit is a reference only; thr 8 -> 8 edges
        run_len_i = 6'd8; avg_sel_i = 2'd0; steer_en_i = 1'b1;
        f0 = found_n;
        drive_bit(1'b0, 0);
        send_alt(7, 100);
        idle(3);
        chk(found_n == f0, "R1 no detection at 7 edges", found_n - f0, 0);
        send_alt(1, 100);
        idle(3);
        chk(found_n == f0 + 1, "R1 detection at 8 edges", found_n - f0, 1);
        chk(steer_phase_o == 10'd100, "R7 window 8 estimate", int'(steer_phase_o), 100);

        // R3: break restarts count and reference
        break_run();
        f0 = found_n;
        send_alt(5, 300);
        break_run();
        send_alt(8, 600);
        idle(3);
        chk(found_n == f0 + 1, "R3 one detection after break", found_n - f0, 1);
        chk(steer_phase_o == 10'd600, "R3 fresh reference", int'(steer_phase_o), 600);

        // R4: long preamble gives repeated detections
        break_run();
        f0 = found_n;
        send_alt(32, 50);
        idle(3);
        chk(found_n == f0 + 4, "R4 four detections", found_n - f0, 4);

        // R5: flag without steer when disabled (scoreboard checks steer)
        break_run();
        steer_en_i = 1'b0;
        f0 = found_n;
        send_alt(8, 700);
        idle(3);
        chk(found_n == f0 + 1, "R5 flag while disabled", found_n - f0, 1);
        chk(steer_phase_o == 10'd700, "R8 phase loads while disabled", int'(steer_phase_o), 700);
        steer_en_i = 1'b1;

        // R2: threshold code 0 means 64
        break_run();
        run_len_i = 6'd0;
        f0 = found_n;
        send_alt(63, 10);
        idle(3);
        chk(found_n == f0, "R2 none at 63 edges", found_n - f0, 0);
        send_alt(1, 10);
        idle(3);
        chk(found_n == f0 + 1, "R2 detection at 64 edges", found_n - f0, 1);

        // R6: noisy preamble around the wrap point, mean 1020
        break_run();
        run_len_i = 6'd32; avg_sel_i = 2'd1;
        for (int i = 0; i < 32; i++) begin
            int offs;
            case (i % 8)
                0: offs = 3;  1: offs = -3; 2: offs = 5;  3: offs = -5;
                4: offs = 1;  5: offs = -1; 6: offs = 6;  default: offs = -6;
            endcase
            drive_bit(!m_prev, 1020 + offs + 1024);
        end
        idle(3);
        d = (int'(steer_phase_o) - 1020) & 1023;
        if (d >= 512) d = d - 1024;
        chk(d >= -1 && d <= 1, "R6 wrap-safe mean", int'(steer_phase_o), 1020);

        // R7: window selection and clamping with thr 40
        run_len_i = 6'd40;
        break_run();
        avg_sel_i = 2'd0;
        send_alt(16, 200);
        send_alt(24, 400);
        idle(3);
        chk(steer_phase_o == 10'd200, "R7 window 16", int'(steer_phase_o), 200);
        break_run();
        avg_sel_i = 2'd2;
        send_alt(16, 200);
        send_alt(24, 400);
        idle(3);
        chk(steer_phase_o == 10'd300, "R7 window clamped to 32", int'(steer_phase_o), 300);

        // R9: gaps do not break a run
        break_run();
        run_len_i = 6'd8; avg_sel_i = 2'd0;
        f0 = found_n;
        for (int i = 0; i < 8; i++) begin
            drive_bit(!m_prev, 900);
            idle(2);
        end
        idle(3);
        chk(found_n == f0 + 1, "R9 detection across gaps", found_n - f0, 1);
        chk(steer_phase_o == 10'd900, "R9 phase across gaps", int'(steer_phase_o), 900);

        // Random data: no detection at threshold 32
        break_run();
        run_len_i = 6'd32;
        f0 = found_n;
        for (int i = 0; i < 2000; i++) drive_bit(1'($urandom), int'($urandom % 1024));
        idle(4);
        chk(found_n == f0, "R1 no detection on random data", found_n - f0, 0);
        chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule